// File: doc/BRIEF.md
# RS485 Serial Transmitter with Driver-Enable Timing

This block serialises one data word at a time onto an asynchronous line and drives the driver-enable control of an RS485 transceiver around every transmission. A word is handed over with a valid/ready handshake. The block raises the driver enable, waits a programmable number of oversampling ticks, and sends the frame: a start bit, the payload least significant bit first, and a stop bit. After the stop bit it holds the driver enable for a second programmable number of ticks and then releases it.

Time is counted only in sample ticks, which an external baud generator supplies as a one-cycle enable. A configuration bit selects either 16 or 8 ticks per bit. A two-bit length code and a parity-enable bit choose the payload. When parity is on, the parity bit takes the place of the payload's top data bit, so the frame length does not change. If the next word is already waiting when the current stop bit ends, the next frame follows at once. In that case the driver enable stays active, and neither the release delay nor the lead delay is inserted.

All configuration inputs are captured when a word is accepted from idle. They are ignored while the block is busy.

Top module: `rs485_tx_de`

## Requirements
- R1: After reset and whenever idle: `tx`=1, `busy`=0, `in_ready`=1, and `de` sits at its inactive level.
- R2: A frame is one start bit (0), the payload least significant bit first, and one stop bit (1). Each bit lasts 16 ticks when `cfg_os_narrow`=0 and 8 ticks when it is 1.
- R3: The payload width is set by `cfg_len`: 2'b00 gives 8 bit positions, 2'b01 gives 9, 2'b10 gives 7, and 2'b11 behaves as 2'b00. Bits of `in_data` above the payload width are not sent.
- R4: With `cfg_par_en`=1, the top payload position carries a parity bit computed over the lower payload bits: even parity when `cfg_par_odd`=0, odd when 1. The data bit at that position is dropped.
- R5: `de` is active for exactly `cfg_lead` ticks before the start bit. A value of 0 makes the start bit begin in the same cycle that `de` becomes active.
- R6: After the end of the last stop bit, `de` stays active for exactly `cfg_lag` ticks and then returns to inactive. With 0 it is released at once.
- R7: `cfg_de_low`=0 makes `de` active high, and 1 makes it active low. In idle the pin shows the inactive level for the current setting.
- R8: A word offered no later than the final tick of a stop bit starts its start bit right after that stop bit, with `de` kept active and no lag or lead ticks.
- R9: Configuration is captured only when a word is accepted from idle. Changes while busy do not affect the current frame, its lag, or back-to-back frames that follow it.
- R10: While busy, `in_ready` is high only in the cycle that carries the final tick of a stop bit. While busy, `tx` changes only at the end of a tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick enable, one cycle wide |
| cfg_len | input | 2 | Payload width code |
| cfg_par_en | input | 1 | Parity replaces the top payload bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_os_narrow | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| cfg_de_low | input | 1 | 1 = driver enable active low |
| cfg_lead | input | 5 | Ticks of driver enable before the start bit |
| cfg_lag | input | 5 | Ticks of driver enable after the stop bit |
| in_valid | input | 1 | Word offered |
| in_data | input | 9 | Word to send |
| in_ready | output | 1 | Word taken when high together with in_valid |
| tx | output | 1 | Serial line, idle high |
| de | output | 1 | Transceiver driver enable |
| busy | output | 1 | Driver-enable sequence in progress |

## Verification
The hardest condition to reach is the back-to-back handoff. `in_ready` rises for a single cycle only, and only when a tick lands on the last sample of a stop bit, so a follow-on word must already be waiting at that moment. To get there, the stimulus raises the next word in the cycle after the previous one is accepted and holds it across the whole frame, while ticks arrive at random intervals. A second hard case is a configuration change in the middle of a frame. The stimulus scrambles every configuration pin except polarity right after acceptance, keeps them scrambled through a following back-to-back frame, and checks the frames and the release delay against the values captured at acceptance.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

    localparam int MAX_DATA  = 9;
    localparam int TIME_W    = 5;
    localparam int FRAME_W   = MAX_DATA + 2;
    localparam int IDX_W     = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LAG   = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [1:0]        len;
        logic              par_en;
        logic              par_odd;
        logic              os_narrow;
        logic              de_low;
        logic [TIME_W-1:0] lead;
        logic [TIME_W-1:0] lag;
    } tx_cfg_t;

    // Number of payload positions for a width code; code 3 falls back to 8.
    function automatic int payload_len(input logic [1:0] len);
        case (len)
            2'b01:   return 9;
            2'b10:   return 7;
            default: return 8;
        endcase
    endfunction

    // Frame position of the stop bit.
    function automatic logic [IDX_W-1:0] stop_index(input logic [1:0] len);
        return IDX_W'(payload_len(len) + 1);
    endfunction

    // Full frame, position 0 first on the line; unused upper positions are 1.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [MAX_DATA-1:0] word,
                                                       input tx_cfg_t          c);
        logic [FRAME_W-1:0] fr;
        logic               par;
        int                 n;
        n   = payload_len(c.len);
        fr  = '1;
        fr[0] = 1'b0;
        par = c.par_odd;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) begin
                if (c.par_en && (i == n - 1)) begin
                    fr[i+1] = par;
                end else begin
                    fr[i+1] = word[i];
                    par     = par ^ word[i];
                end
            end
        end
        return fr;
    endfunction

endpackage

// File: rtl/rs485_tick_counter.sv
module rs485_tick_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    // Fires on the tick that completes 'limit' ticks since the last clear or wrap.
    assign hit = tick && !clr && (cnt == (limit - W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= hit ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/rs485_tx_ctrl.sv
module rs485_tx_ctrl
    import rs485_tx_pkg::*;
#(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8,
    parameter int SUB_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [MAX_DATA-1:0] in_data,
    input  tx_cfg_t             cfg_in,
    input  logic                bit_hit,
    input  logic                gap_hit,
    output logic                in_ready,
    output tx_state_e           state,
    output tx_cfg_t             cfg_q,
    output logic [FRAME_W-1:0]  frame_q,
    output logic [IDX_W-1:0]    bit_idx,
    output logic [SUB_W-1:0]    bit_limit,
    output logic [TIME_W-1:0]   gap_limit,
    output logic                bit_clr,
    output logic                gap_clr
);

    localparam logic [SUB_W-1:0] LIM_HI = SUB_W'(OS_HI);
    localparam logic [SUB_W-1:0] LIM_LO = SUB_W'(OS_LO);

    logic last_bit;
    logic frame_end;
    logic take;

    assign last_bit  = (bit_idx == stop_index(cfg_q.len));
    assign frame_end = (state == ST_SHIFT) && bit_hit && last_bit;
    assign in_ready  = (state == ST_IDLE) || frame_end;
    assign take      = in_valid && in_ready;

    assign bit_limit = cfg_q.os_narrow ? LIM_LO : LIM_HI;
    assign gap_limit = (state == ST_LEAD) ? cfg_q.lead : cfg_q.lag;
    assign bit_clr   = (state != ST_SHIFT);
    assign gap_clr   = !((state == ST_LEAD) || (state == ST_LAG));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            frame_q <= '1;
            bit_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        cfg_q   <= cfg_in;
                        frame_q <= build_frame(in_data, cfg_in);
                        bit_idx <= '0;
                        state   <= (cfg_in.lead == '0) ? ST_SHIFT : ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (gap_hit) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bit_hit) begin
                        if (!last_bit) begin
                            bit_idx <= bit_idx + IDX_W'(1);
                        end else if (take) begin
                            // follow-on word: keep the latched configuration
                            frame_q <= build_frame(in_data, cfg_q);
                            bit_idx <= '0;
                        end else begin
                            bit_idx <= '0;
                            state   <= (cfg_q.lag == '0) ? ST_IDLE : ST_LAG;
                        end
                    end
                end
                ST_LAG: begin
                    if (gap_hit) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rs485_line_drive.sv
module rs485_line_drive
    import rs485_tx_pkg::*;
(
    input  tx_state_e          state,
    input  logic [FRAME_W-1:0] frame_q,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               held_low,
    input  logic               live_low,
    output logic               tx,
    output logic               de,
    output logic               busy
);

    logic pol_low;

    assign busy    = (state != ST_IDLE);
    assign tx      = (state == ST_SHIFT) ? frame_q[bit_idx] : 1'b1;
    assign pol_low = busy ? held_low : live_low;
    assign de      = busy ^ pol_low;

endmodule

// File: rtl/rs485_tx_de.sv
module rs485_tx_de
    import rs485_tx_pkg::*;
#(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_os_narrow,
    input  logic                cfg_de_low,
    input  logic [TIME_W-1:0]   cfg_lead,
    input  logic [TIME_W-1:0]   cfg_lag,
    input  logic                in_valid,
    input  logic [MAX_DATA-1:0] in_data,
    output logic                in_ready,
    output logic                tx,
    output logic                de,
    output logic                busy
);

    localparam int SUB_W = $clog2(OS_HI) + 1;

    tx_cfg_t            cfg_in;
    tx_cfg_t            cfg_q;
    tx_state_e          state;
    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   bit_idx;
    logic [SUB_W-1:0]   bit_limit;
    logic [TIME_W-1:0]  gap_limit;
    logic               bit_clr;
    logic               gap_clr;
    logic               bit_hit;
    logic               gap_hit;

    assign cfg_in = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                      os_narrow: cfg_os_narrow, de_low: cfg_de_low,
                      lead: cfg_lead, lag: cfg_lag};

    rs485_tx_ctrl #(.OS_HI(OS_HI), .OS_LO(OS_LO), .SUB_W(SUB_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_in    (cfg_in),
        .bit_hit   (bit_hit),
        .gap_hit   (gap_hit),
        .in_ready  (in_ready),
        .state     (state),
        .cfg_q     (cfg_q),
        .frame_q   (frame_q),
        .bit_idx   (bit_idx),
        .bit_limit (bit_limit),
        .gap_limit (gap_limit),
        .bit_clr   (bit_clr),
        .gap_clr   (gap_clr)
    );

    rs485_tick_counter #(.W(SUB_W)) u_bit_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (bit_clr),
        .tick  (tick),
        .limit (bit_limit),
        .hit   (bit_hit)
    );

    rs485_tick_counter #(.W(TIME_W)) u_gap_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (gap_clr),
        .tick  (tick),
        .limit (gap_limit),
        .hit   (gap_hit)
    );

    rs485_line_drive u_drive (
        .state    (state),
        .frame_q  (frame_q),
        .bit_idx  (bit_idx),
        .held_low (cfg_q.de_low),
        .live_low (cfg_de_low),
        .tx       (tx),
        .de       (de),
        .busy     (busy)
    );

endmodule

// File: rtl/rs485_tx_de_chk.sv
module rs485_tx_de_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic in_ready,
    input logic tx,
    input logic de,
    input logic busy
);

    // R1: idle always offers to take a word
    a_r1_idle_ready: assert property (@(posedge clk) disable iff (rst)
        !busy |-> in_ready);

    // R1: idle line level is high
    a_r1_idle_line: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    // R2: a start bit only appears inside a busy sequence
    a_r2_start_in_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(tx) |-> busy);

    // R6: release follows a high line (stop bit or lag)
    a_r6_high_before_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx));

    // R8: driver enable never toggles during a busy stretch
    a_r8_de_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(de));

    // R10: while busy the line moves only after a tick cycle
    a_r10_tx_on_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tick)) |-> $stable(tx));

    // R10: ready during busy only in a tick cycle
    a_r10_ready_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && in_ready) |-> tick);

endmodule

bind rs485_tx_de rs485_tx_de_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .in_ready (in_ready),
    .tx       (tx),
    .de       (de),
    .busy     (busy)
);

// File: tb/sim_rs485_tx_de.sv
module sim_rs485_tx_de;

    localparam int CLK_PERIOD = 10;
    localparam int MAXQ = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_os_narrow = 1'b0;
    logic       cfg_de_low = 1'b0;
    logic [4:0] cfg_lead = 5'd0;
    logic [4:0] cfg_lag = 5'd0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = 9'd0;
    logic       in_ready, tx, de, busy;

    rs485_tx_de u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_os_narrow(cfg_os_narrow), .cfg_de_low(cfg_de_low),
        .cfg_lead(cfg_lead), .cfg_lag(cfg_lag),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx(tx), .de(de), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit tick_all = 1'b0;

    // bench copy of the intended configuration
    logic [1:0] v_len; bit v_pe, v_po, v_os8, v_low; int v_lead, v_lag;

    // expected frame queue
    logic [10:0] e_frame [MAXQ];
    int          e_n     [MAXQ];
    bit          e_os8   [MAXQ];
    int          e_lead  [MAXQ];
    int          e_lag   [MAXQ];
    bit          e_b2b   [MAXQ];
    int          e_kind  [MAXQ];
    int wr_ptr = 0;
    int rd_ptr = 0;

    // monitor state
    int mst = 0;
    int gap = 0;
    int tcnt = 0;
    int cur = 0;
    int last_lag = 0;
    bit from_out = 1'b0;
    bit have_lag = 1'b0;
    bit ready_bad = 1'b0;
    logic [10:0] got;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [8:0] w, input logic [1:0] len,
                                              input bit pe, input bit po);
        int n; logic [8:0] d; logic [10:0] f; bit p;
        n = (len == 2'b01) ? 9 : ((len == 2'b10) ? 7 : 8);
        d = w & ((9'h1 << n) - 9'h1);
        if (pe) begin
            d[n-1] = 1'b0;
            p = po ^ (^d);
            d[n-1] = p;
        end
        f = 11'h7FF;
        f[0] = 1'b0;
        for (int i = 0; i < n; i++) f[i+1] = d[i];
        return f;
    endfunction

    task automatic frame_step();
        int os, tot;
        string tag;
        os  = e_os8[cur] ? 8 : 16;
        tot = (e_n[cur] + 2) * os;
        if (in_ready && !(tick && tcnt == tot - 1)) ready_bad = 1'b1;
        if (tick) begin
            if (tcnt == tot - 1) chk(in_ready, "R10 ready at final stop tick", int'(in_ready), 1);
            if (tcnt % os == os / 2) got[tcnt / os] = tx;
            tcnt++;
            if (tcnt == tot) begin
                tag = (e_kind[cur] == 2) ? "R4 parity frame" :
                      ((e_kind[cur] == 1) ? "R3 length frame" : "R2 frame bits");
                chk(got == e_frame[cur], tag, int'(got), int'(e_frame[cur]));
                chk(!ready_bad, "R10 ready inside frame", int'(ready_bad), 0);
                mst = 1; gap = 0; from_out = 1'b0;
                last_lag = e_lag[cur]; have_lag = 1'b1;
            end
        end
    endtask

    task automatic start_frame();
        chk(rd_ptr < wr_ptr, "R2 unexpected frame", rd_ptr, wr_ptr);
        cur = rd_ptr % MAXQ;
        if (e_b2b[cur])
            chk(!from_out && gap == 0, "R8 back-to-back start", gap, 0);
        else
            chk(from_out && gap == e_lead[cur], "R5 lead ticks", gap, e_lead[cur]);
        rd_ptr++;
        mst = 2; tcnt = 0; got = '1; ready_bad = 1'b0; have_lag = 1'b0;
        frame_step();
    endtask

    always @(negedge clk) begin
        bit de_act;
        if (!rst) begin
            de_act = de ^ cfg_de_low;
            case (mst)
                0: begin
                    if (de_act) begin
                        mst = 1; gap = 0; from_out = 1'b1;
                        if (tx == 1'b0) start_frame();
                        else if (tick) gap++;
                    end
                end
                1: begin
                    if (!de_act) begin
                        if (have_lag) chk(gap == last_lag, "R6 lag ticks", gap, last_lag);
                        have_lag = 1'b0;
                        mst = 0;
                    end else if (tx == 1'b0) begin
                        start_frame();
                    end else if (tick) begin
                        gap++;
                    end
                end
                default: begin
                    if (!de_act) chk(1'b0, "R8 DE dropped inside frame", 0, 1);
                    frame_step();
                end
            endcase
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick = tick_all ? 1'b1 : 1'($urandom);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic set_cfg(input logic [1:0] len, input bit pe, input bit po, input bit os8,
                           input bit low, input int lead, input int lag);
        @(posedge clk); #1;
        v_len = len; v_pe = pe; v_po = po; v_os8 = os8; v_low = low;
        v_lead = lead; v_lag = lag;
        cfg_len = len; cfg_par_en = pe; cfg_par_odd = po; cfg_os_narrow = os8;
        cfg_de_low = low; cfg_lead = 5'(lead); cfg_lag = 5'(lag);
    endtask

    task automatic send_words(input int cnt, input bit scramble);
        for (int k = 0; k < cnt; k++) begin
            logic [8:0] w;
            int idx;
            w = 9'($urandom);
            @(posedge clk); #1;
            in_data = w; in_valid = 1'b1;
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk);
            idx = wr_ptr % MAXQ;
            e_frame[idx] = exp_frame(w, v_len, v_pe, v_po);
            e_n[idx]     = (v_len == 2'b01) ? 9 : ((v_len == 2'b10) ? 7 : 8);
            e_os8[idx]   = v_os8;
            e_lead[idx]  = v_lead;
            e_lag[idx]   = v_lag;
            e_b2b[idx]   = (k > 0);
            e_kind[idx]  = v_pe ? 2 : ((v_len != 2'b00) ? 1 : 0);
            wr_ptr++;
            #1;
            in_valid = 1'b0;
            if (scramble && k == 0) begin
                // R9: configuration pins change while busy
                cfg_len = ~v_len; cfg_par_en = ~v_pe; cfg_par_odd = ~v_po;
                cfg_os_narrow = ~v_os8; cfg_lead = 5'($urandom); cfg_lag = ~5'(v_lag);
            end
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (busy && t < 20000);
        chk(t < 20000, "R6 return to idle", t, 20000);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(tx == 1'b1, "R1 reset tx", int'(tx), 1);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        chk(de == 1'b0, "R1 reset de", int'(de), 0);

        // R7: active-low setting shows a high idle level and a low level when busy
        set_cfg(2'b00, 0, 0, 0, 1, 5, 3);
        @(negedge clk);
        chk(de == 1'b1, "R7 idle level active-low", int'(de), 1);
        send_words(1, 0);
        @(negedge clk);
        chk(de == 1'b0 && busy, "R7 active level low", int'(de), 0);
        wait_idle();
        chk(de == 1'b1, "R7 release level active-low", int'(de), 1);

        // R2 R3 R4: every width code with and without parity, full tick rate
        tick_all = 1'b1;
        for (int c = 0; c < 8; c++) begin
            set_cfg(2'(c >> 1), bit'(c & 1), bit'(c >> 2), bit'(c & 1), 0,
                    (c % 3 == 0) ? 0 : 31, (c % 2 == 0) ? 31 : 0);
            send_words(1, 0);
            wait_idle();
        end
        tick_all = 1'b0;

        // R4: odd and even parity on a narrow payload
        set_cfg(2'b10, 1, 1, 1, 0, 1, 1);
        send_words(2, 0);
        wait_idle();
        set_cfg(2'b10, 1, 0, 0, 0, 0, 0);
        send_words(2, 0);
        wait_idle();

        // R8: back-to-back burst with lag and lead both zero and both nonzero
        set_cfg(2'b00, 0, 0, 1, 0, 0, 0);
        send_words(3, 0);
        wait_idle();
        set_cfg(2'b01, 1, 1, 0, 1, 17, 9);
        send_words(3, 0);
        wait_idle();

        // R9: scramble configuration pins during a two-frame burst
        set_cfg(2'b01, 0, 1, 1, 0, 6, 12);
        send_words(2, 1);
        wait_idle();
        set_cfg(v_len, v_pe, v_po, v_os8, v_low, v_lead, v_lag);

        // random mix
        for (int r = 0; r < 45; r++) begin
            set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    int'(5'($urandom)), int'(5'($urandom)));
            send_words(1 + int'($urandom % 3), (r % 7) == 3);
            wait_idle();
            set_cfg(v_len, v_pe, v_po, v_os8, v_low, v_lead, v_lag);
        end

        chk(rd_ptr == wr_ptr, "R2 all frames observed", rd_ptr, wr_ptr);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule